// File: doc/BRIEF.md
# Operand Bypass and Load-Use Stall Unit

This block steers operands around the register file in a five-stage in-order pipeline (fetch, decode/register-read, ALU, data memory, register write). For each of the two ALU inputs it picks one of three values: the operand captured at register read, the result sitting in the ALU-to-memory latch, or the result sitting in the memory-to-writeback latch. It also picks the write data presented to data memory by a store, so that a value loaded by the instruction just ahead can be stored without waiting.

The selects for an instruction are worked out while it sits in decode, by comparing its source registers with the destinations of the instructions ahead of it. They are registered, so they are ready when that instruction reaches the ALU. When a load is directly followed by an instruction that needs the loaded value inside the ALU, the unit raises a stall. Fetch and decode then hold, and an empty slot with every enable cleared goes into the ALU stage. The operand muxes themselves are part of the block so that the steering can be seen at its data outputs.

Top module: `bypass_unit`

## Requirements
- R1: After reset both operand selects read 0 (register-read value), the store-data select reads 0 (latched store data) and stall is low while no load is in the ALU stage.
- R2: An operand whose register is written by a non-load instruction one position ahead gets select 1, and the ALU input equals the ALU-to-memory latch value, with no stall.
- R3: An operand whose register is written two positions ahead, and not one ahead, gets select 2, and the ALU input equals the memory-to-writeback latch value.
- R4: When the instructions one and two ahead both write the operand's register, the nearer one wins (select 1).
- R5: A producer whose write enable is low, or whose destination is register 0, is never forwarded and never causes a stall.
- R6: A load followed directly by an instruction that uses the loaded register as an ALU operand (including a load or store base address) raises stall and bubble for exactly one cycle. During that cycle the next ALU-stage write, load and store enables are 0. The ALU stage then holds an empty slot with select 0, and after that the consumer reaches the ALU with select 2.
- R7: A load followed directly by a store whose data register is the loaded register does not stall. When that store reaches the memory stage, the store-data select is 1 and the memory write data equals the memory-to-writeback latch value.
- R8: An ALU result used as the base address of the next instruction, a load, is forwarded with select 1 and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| drSrcA | input | REG_W | Decode-stage source register for operand A |
| drSrcB | input | REG_W | Decode-stage source register for operand B (store data for stores) |
| drUseA | input | 1 | Decode-stage instruction reads operand A |
| drUseB | input | 1 | Decode-stage instruction reads operand B |
| drWe | input | 1 | Decode-stage instruction writes a register |
| drIsLoad | input | 1 | Decode-stage instruction is a load |
| drIsStore | input | 1 | Decode-stage instruction is a store |
| exDst | input | REG_W | ALU-stage destination register |
| exWe | input | 1 | ALU-stage write enable |
| exIsLoad | input | 1 | ALU-stage instruction is a load |
| exIsStore | input | 1 | ALU-stage instruction is a store |
| exSrcB | input | REG_W | ALU-stage store data register |
| dmDst | input | REG_W | Memory-stage destination register |
| dmWe | input | 1 | Memory-stage write enable |
| dmIsLoad | input | 1 | Memory-stage instruction is a load |
| exOpA | input | DATA_W | Register-read value for operand A |
| exOpB | input | DATA_W | Register-read value for operand B |
| aluDmVal | input | DATA_W | Result held in the ALU-to-memory latch |
| dmRwVal | input | DATA_W | Result held in the memory-to-writeback latch |
| dmStoreIn | input | DATA_W | Store data carried into the memory stage |
| selA | output | 2 | Operand A select (0 register read, 1 ALU latch, 2 memory latch) |
| selB | output | 2 | Operand B select, same encoding |
| stSel | output | 1 | Store-data select (0 latched, 1 memory latch) |
| stall | output | 1 | Hold fetch and decode this cycle |
| bubble | output | 1 | Insert an empty slot into the ALU stage |
| aluInA | output | DATA_W | Selected ALU operand A |
| aluInB | output | DATA_W | Selected ALU operand B |
| memWrData | output | DATA_W | Selected memory write data |
| nextExWe | output | 1 | Write enable to load into the ALU stage |
| nextExLoad | output | 1 | Load flag to load into the ALU stage |
| nextExStore | output | 1 | Store flag to load into the ALU stage |

## Verification
The bench goes after the places where a comparison is easy to get wrong. Take two producers of one register: a unit that preferred the older one would hand the ALU a stale value. Take a load right before its consumer: forwarding from the ALU latch there would pass on an address instead of data, and a missing stall would leave that value in place. A stall held too long would waste a cycle and duplicate the consumer. A load feeding a store's data is the reverse case: a unit that stalled on it, or never switched the store-data mux, would show either a lost cycle or the old register value at the memory port. Register 0 and non-writing producers are covered as well, since a unit that ignored the write enable or the zero register would forward garbage or stall when it should not.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

  typedef enum logic [1:0] {
    SRC_RR    = 2'd0,
    SRC_ALUDM = 2'd1,
    SRC_DMRW  = 2'd2
  } fwdSrc_t;

  typedef struct packed {
    fwdSrc_t opA;
    fwdSrc_t opB;
    logic    stData;
    logic    bubble;
  } bypStrobes_t;

endpackage

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import bypass_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] drSrcA,
  input  logic [REG_W-1:0] drSrcB,
  input  logic             drUseA,
  input  logic             drUseB,
  input  logic             drIsStore,
  input  logic [REG_W-1:0] exDst,
  input  logic             exWe,
  input  logic             exIsLoad,
  input  logic             exIsStore,
  input  logic [REG_W-1:0] exSrcB,
  input  logic [REG_W-1:0] dmDst,
  input  logic             dmWe,
  input  logic             dmIsLoad,
  output bypStrobes_t      strobes,
  output logic             stall
);

  localparam int NUM_OPS = 2;
  localparam int DATA_OP = 1;

  function automatic logic hits(input logic [REG_W-1:0] src,
                                input logic [REG_W-1:0] dst,
                                input logic en);
    return en && (dst != '0) && (src == dst);
  endfunction

  logic [NUM_OPS-1:0] loadHit;
  logic               stDataQ;

  generate
    for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
      localparam bit IS_DATA = (i == DATA_OP);
      logic [REG_W-1:0] src;
      logic             used;
      fwdSrc_t          nxtSel;
      fwdSrc_t          selQ;

      assign src  = IS_DATA ? drSrcB : drSrcA;
      assign used = IS_DATA ? drUseB : drUseA;

      // Nearest producer first; loads in the ALU stage have no result yet.
      always_comb begin
        nxtSel = SRC_RR;
        if (used && hits(src, exDst, exWe && !exIsLoad))
          nxtSel = SRC_ALUDM;
        else if (used && hits(src, dmDst, dmWe))
          nxtSel = SRC_DMRW;
      end

      // A store's data operand is picked up later in the memory stage.
      assign loadHit[i] = used && hits(src, exDst, exWe && exIsLoad)
                          && !(IS_DATA && drIsStore);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     selQ <= SRC_RR;
        else if (stall) selQ <= SRC_RR;
        else            selQ <= nxtSel;
      end
    end
  endgenerate

  assign stall = |loadHit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stDataQ <= 1'b0;
    else        stDataQ <= exIsStore && hits(exSrcB, dmDst, dmWe && dmIsLoad);
  end

  always_comb begin
    strobes.opA    = g_op[0].selQ;
    strobes.opB    = g_op[1].selQ;
    strobes.stData = stDataQ;
    strobes.bubble = stall;
  end

endmodule

// File: rtl/bypass_datapath.sv
module bypass_datapath
  import bypass_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  bypStrobes_t       strobes,
  input  logic [DATA_W-1:0] exOpA,
  input  logic [DATA_W-1:0] exOpB,
  input  logic [DATA_W-1:0] aluDmVal,
  input  logic [DATA_W-1:0] dmRwVal,
  input  logic [DATA_W-1:0] dmStoreIn,
  input  logic              drWe,
  input  logic              drIsLoad,
  input  logic              drIsStore,
  output logic [DATA_W-1:0] aluInA,
  output logic [DATA_W-1:0] aluInB,
  output logic [DATA_W-1:0] memWrData,
  output logic              nextExWe,
  output logic              nextExLoad,
  output logic              nextExStore
);

  function automatic logic [DATA_W-1:0] pick(input fwdSrc_t sel,
                                             input logic [DATA_W-1:0] rr);
    case (sel)
      SRC_ALUDM: return aluDmVal;
      SRC_DMRW:  return dmRwVal;
      default:   return rr;
    endcase
  endfunction

  always_comb begin
    aluInA    = pick(strobes.opA, exOpA);
    aluInB    = pick(strobes.opB, exOpB);
    memWrData = strobes.stData ? dmRwVal : dmStoreIn;
  end

  // Empty slot: every enable heading into the ALU stage is dropped.
  assign nextExWe    = drWe      && !strobes.bubble;
  assign nextExLoad  = drIsLoad  && !strobes.bubble;
  assign nextExStore = drIsStore && !strobes.bubble;

endmodule

// File: rtl/bypass_unit.sv
module bypass_unit
  import bypass_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  drSrcA,
  input  logic [REG_W-1:0]  drSrcB,
  input  logic              drUseA,
  input  logic              drUseB,
  input  logic              drWe,
  input  logic              drIsLoad,
  input  logic              drIsStore,
  input  logic [REG_W-1:0]  exDst,
  input  logic              exWe,
  input  logic              exIsLoad,
  input  logic              exIsStore,
  input  logic [REG_W-1:0]  exSrcB,
  input  logic [REG_W-1:0]  dmDst,
  input  logic              dmWe,
  input  logic              dmIsLoad,
  input  logic [DATA_W-1:0] exOpA,
  input  logic [DATA_W-1:0] exOpB,
  input  logic [DATA_W-1:0] aluDmVal,
  input  logic [DATA_W-1:0] dmRwVal,
  input  logic [DATA_W-1:0] dmStoreIn,
  output logic [1:0]        selA,
  output logic [1:0]        selB,
  output logic              stSel,
  output logic              stall,
  output logic              bubble,
  output logic [DATA_W-1:0] aluInA,
  output logic [DATA_W-1:0] aluInB,
  output logic [DATA_W-1:0] memWrData,
  output logic              nextExWe,
  output logic              nextExLoad,
  output logic              nextExStore
);

  bypStrobes_t strobes;

  hazard_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .drSrcA   (drSrcA),
    .drSrcB   (drSrcB),
    .drUseA   (drUseA),
    .drUseB   (drUseB),
    .drIsStore(drIsStore),
    .exDst    (exDst),
    .exWe     (exWe),
    .exIsLoad (exIsLoad),
    .exIsStore(exIsStore),
    .exSrcB   (exSrcB),
    .dmDst    (dmDst),
    .dmWe     (dmWe),
    .dmIsLoad (dmIsLoad),
    .strobes  (strobes),
    .stall    (stall)
  );

  bypass_datapath #(.DATA_W(DATA_W)) u_dp (
    .strobes    (strobes),
    .exOpA      (exOpA),
    .exOpB      (exOpB),
    .aluDmVal   (aluDmVal),
    .dmRwVal    (dmRwVal),
    .dmStoreIn  (dmStoreIn),
    .drWe       (drWe),
    .drIsLoad   (drIsLoad),
    .drIsStore  (drIsStore),
    .aluInA     (aluInA),
    .aluInB     (aluInB),
    .memWrData  (memWrData),
    .nextExWe   (nextExWe),
    .nextExLoad (nextExLoad),
    .nextExStore(nextExStore)
  );

  assign selA   = strobes.opA;
  assign selB   = strobes.opB;
  assign stSel  = strobes.stData;
  assign bubble = strobes.bubble;

endmodule

// File: rtl/bypass_unit_chk.sv
module bypass_unit_chk #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_W-1:0]  drSrcA,
  input logic [REG_W-1:0]  drSrcB,
  input logic              drUseA,
  input logic              drUseB,
  input logic              drIsStore,
  input logic [REG_W-1:0]  exDst,
  input logic              exWe,
  input logic              exIsLoad,
  input logic [DATA_W-1:0] aluDmVal,
  input logic [DATA_W-1:0] dmRwVal,
  input logic [1:0]        selA,
  input logic [1:0]        selB,
  input logic              stSel,
  input logic              stall,
  input logic              bubble,
  input logic [DATA_W-1:0] aluInA,
  input logic [DATA_W-1:0] aluInB,
  input logic [DATA_W-1:0] memWrData,
  input logic              nextExWe,
  input logic              nextExLoad,
  input logic              nextExStore
);

  // R2: operand A taken from the ALU latch when so selected
  a_r2_mux_alu_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (selA == 2'd1) |-> (aluInA == aluDmVal));

  // R3: operand B taken from the memory latch when so selected
  a_r3_mux_mem_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (selB == 2'd2) |-> (aluInB == dmRwVal));

  // R1: selects never take the unused code
  a_r1_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (selA != 2'd3) && (selB != 2'd3));

  // R5: a zero destination in the ALU stage never stalls
  a_r5_zero_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (exDst == '0) |-> !stall);

  // R6: the slot after a bubble carries register-read selects
  a_r6_bubble_clears_sel: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> (selA == 2'd0) && (selB == 2'd0));

  // R6: the empty slot has no enables
  a_r6_bubble_no_enables: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |-> !nextExWe && !nextExLoad && !nextExStore);

  // R7: a load feeding only a store's data does not stall
  a_r7_store_data_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (exWe && exIsLoad && drIsStore && drUseB && (drSrcB == exDst)
     && !(drUseA && (drSrcA == exDst))) |-> !stall);

  // R7: store data comes from the memory latch when so selected
  a_r7_store_mux: assert property (@(posedge clk) disable iff (!rst_n)
    stSel |-> (memWrData == dmRwVal));

endmodule

bind bypass_unit bypass_unit_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .drSrcA(drSrcA), .drSrcB(drSrcB),
  .drUseA(drUseA), .drUseB(drUseB), .drIsStore(drIsStore),
  .exDst(exDst), .exWe(exWe), .exIsLoad(exIsLoad),
  .aluDmVal(aluDmVal), .dmRwVal(dmRwVal), .selA(selA), .selB(selB),
  .stSel(stSel), .stall(stall), .bubble(bubble), .aluInA(aluInA),
  .aluInB(aluInB), .memWrData(memWrData), .nextExWe(nextExWe),
  .nextExLoad(nextExLoad), .nextExStore(nextExStore)
);

// File: tb/bypass_unit_bench.sv
module bypass_unit_bench;

  localparam int REG_W  = 5;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] V_OPA = 32'h1111_0001;
  localparam logic [DATA_W-1:0] V_OPB = 32'h2222_0002;
  localparam logic [DATA_W-1:0] V_ALU = 32'hAAAA_000A;
  localparam logic [DATA_W-1:0] V_MEM = 32'hDDDD_000D;
  localparam logic [DATA_W-1:0] V_STO = 32'h5555_0005;

  typedef struct packed {
    logic [REG_W-1:0] srcA;
    logic [REG_W-1:0] srcB;
    logic             useA;
    logic             useB;
    logic [REG_W-1:0] dst;
    logic             we;
    logic             isLoad;
    logic             isStore;
  } instr_t;

  localparam instr_t NOP = '0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  instr_t drI = NOP, exI = NOP, dmI = NOP, rwI = NOP;
  instr_t prog [8];
  int pc = 0;
  int total = 0;
  int fails = 0;

  logic [1:0]        selA, selB;
  logic              stSel, stall, bubble;
  logic [DATA_W-1:0] aluInA, aluInB, memWrData;
  logic              nextExWe, nextExLoad, nextExStore;

  bypass_unit #(.REG_W(REG_W), .DATA_W(DATA_W)) u_bypass_unit (
    .clk(clk), .rst_n(rst_n),
    .drSrcA(drI.srcA), .drSrcB(drI.srcB), .drUseA(drI.useA), .drUseB(drI.useB),
    .drWe(drI.we), .drIsLoad(drI.isLoad), .drIsStore(drI.isStore),
    .exDst(exI.dst), .exWe(exI.we), .exIsLoad(exI.isLoad),
    .exIsStore(exI.isStore), .exSrcB(exI.srcB),
    .dmDst(dmI.dst), .dmWe(dmI.we), .dmIsLoad(dmI.isLoad),
    .exOpA(V_OPA), .exOpB(V_OPB), .aluDmVal(V_ALU), .dmRwVal(V_MEM),
    .dmStoreIn(V_STO),
    .selA(selA), .selB(selB), .stSel(stSel), .stall(stall), .bubble(bubble),
    .aluInA(aluInA), .aluInB(aluInB), .memWrData(memWrData),
    .nextExWe(nextExWe), .nextExLoad(nextExLoad), .nextExStore(nextExStore)
  );

  function automatic instr_t alu(int d, int a, int b);
    instr_t x = NOP;
    x.dst = REG_W'(d); x.srcA = REG_W'(a); x.srcB = REG_W'(b);
    x.useA = 1'b1; x.useB = 1'b1; x.we = 1'b1;
    return x;
  endfunction

  function automatic instr_t ld(int d, int base);
    instr_t x = NOP;
    x.dst = REG_W'(d); x.srcA = REG_W'(base); x.useA = 1'b1;
    x.we = 1'b1; x.isLoad = 1'b1;
    return x;
  endfunction

  function automatic instr_t st(int base, int data, int junkDst);
    instr_t x = NOP;
    x.srcA = REG_W'(base); x.srcB = REG_W'(data); x.useA = 1'b1; x.useB = 1'b1;
    x.dst = REG_W'(junkDst); x.isStore = 1'b1;
    return x;
  endfunction

  task automatic chk(string req, string what, logic [DATA_W-1:0] act,
                     logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic startProg();
    for (int i = 0; i < 8; i++) prog[i] = NOP;
  endtask

  task automatic launch();
    @(posedge clk); #2;
    rwI = NOP; dmI = NOP; exI = NOP; drI = NOP;
    @(posedge clk); #2;
    drI = prog[0]; pc = 1; #2;
  endtask

  task automatic adv();
    logic wasStall;
    wasStall = stall;
    @(posedge clk); #2;
    rwI = dmI; dmI = exI;
    if (wasStall) exI = NOP;
    else begin
      exI = drI;
      drI = (pc < 8) ? prog[pc] : NOP;
      pc++;
    end
    #2;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #3;
    chk("R1", "selA", selA, 0);
    chk("R1", "selB", selB, 0);
    chk("R1", "stSel", stSel, 0);
    chk("R1", "stall", stall, 0);
    chk("R1", "memWrData", memWrData, V_STO);
    rst_n = 1'b1;
  endtask

  task automatic t_r2_next();
    startProg(); prog[0] = alu(3, 1, 2); prog[1] = alu(5, 3, 4);
    launch(); adv();
    chk("R2", "stall", stall, 0);
    adv();
    chk("R2", "selA", selA, 1);
    chk("R2", "aluInA", aluInA, V_ALU);
    chk("R2", "selB", selB, 0);
    chk("R2", "aluInB", aluInB, V_OPB);
  endtask

  task automatic t_r3_two_ahead();
    startProg(); prog[0] = alu(3, 1, 2); prog[1] = alu(7, 8, 10); prog[2] = alu(9, 6, 3);
    launch(); adv(); adv(); adv();
    chk("R3", "selB", selB, 2);
    chk("R3", "aluInB", aluInB, V_MEM);
    chk("R3", "selA", selA, 0);
  endtask

  task automatic t_r4_priority();
    startProg(); prog[0] = alu(4, 1, 2); prog[1] = alu(4, 5, 6); prog[2] = alu(7, 4, 4);
    launch(); adv(); adv(); adv();
    chk("R4", "selA", selA, 1);
    chk("R4", "selB", selB, 1);
  endtask

  task automatic t_r5_no_forward();
    startProg(); prog[0] = alu(0, 1, 2); prog[1] = st(6, 3, 5); prog[2] = alu(8, 0, 5);
    launch(); adv(); adv(); adv();
    chk("R5", "selA zero reg", selA, 0);
    chk("R5", "selB write disabled", selB, 0);
    startProg(); prog[0] = ld(0, 1); prog[1] = alu(9, 0, 0);
    launch(); adv();
    chk("R5", "stall zero reg", stall, 0);
  endtask

  task automatic t_r6_load_use();
    startProg(); prog[0] = ld(1, 2); prog[1] = alu(5, 6, 1);
    launch(); adv();
    chk("R6", "stall", stall, 1);
    chk("R6", "bubble", bubble, 1);
    chk("R6", "nextExWe", nextExWe, 0);
    adv();
    chk("R6", "stall one cycle", stall, 0);
    chk("R6", "selB on empty slot", selB, 0);
    adv();
    chk("R6", "selB after stall", selB, 2);
    chk("R6", "aluInB after stall", aluInB, V_MEM);
    startProg(); prog[0] = ld(1, 2); prog[1] = st(1, 7, 0);
    launch(); adv();
    chk("R6", "stall on store base", stall, 1);
  endtask

  task automatic t_r7_load_store();
    startProg(); prog[0] = ld(1, 2); prog[1] = st(3, 1, 0);
    launch(); adv();
    chk("R7", "stall", stall, 0);
    adv();
    chk("R7", "selB in ALU", selB, 0);
    adv();
    chk("R7", "stSel", stSel, 1);
    chk("R7", "memWrData", memWrData, V_MEM);
    startProg(); prog[0] = alu(1, 2, 4); prog[1] = st(3, 1, 0);
    launch(); adv(); adv(); adv();
    chk("R7", "stSel after ALU producer", stSel, 0);
  endtask

  task automatic t_r8_load_base();
    startProg(); prog[0] = alu(1, 2, 3); prog[1] = ld(4, 1);
    launch(); adv();
    chk("R8", "stall", stall, 0);
    adv();
    chk("R8", "selA", selA, 1);
    chk("R8", "aluInA", aluInA, V_ALU);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_r2_next();
    t_r3_two_ahead();
    t_r4_priority();
    t_r5_no_forward();
    t_r6_load_use();
    t_r7_load_store();
    t_r8_load_base();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule